// File: doc/BRIEF.md
# Cartridge Program/Pattern Bank Mapper

This block is the bank-switching core of a cartridge memory mapper for an 8-bit game console. The CPU writes into a register window in the upper half of its address space. A command register picks one of eight 8-bit bank registers and two layout modes. A following data write fills the selected register. A separate write sets the nametable mirroring bit.

From this state the block computes two bank numbers. One is the physical 8 KB program bank for each of the four CPU windows at 0x8000, 0xA000, 0xC000 and 0xE000. The other is the physical 1 KB pattern bank for each of the eight pattern-table windows selected by PPU address bits 12:10. Both lookups are combinational: the caller presents a window index and reads the bank number in the same cycle. The program bank count and the pattern bank count are parameters and must be powers of two. Every bank number is reduced modulo its count.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write (wr_en high) to an address with bits 15:13 = 100 and bit 0 = 0 loads the command register from data bit 7 (pattern flip), bit 6 (program swap) and bits 2:0 (register select). The new value takes effect from the next clock edge.
- R2: A write to an address with bits 15:13 = 100 and bit 0 = 1 stores the data byte into the bank register numbered by the current register select.
- R3: With pattern flip clear, pattern windows 0, 1, 2 and 3 give register 0 with bit 0 cleared, register 0 with bit 0 set, register 1 with bit 0 cleared and register 1 with bit 0 set.
- R4: With pattern flip clear, pattern windows 4, 5, 6 and 7 give registers 2, 3, 4 and 5.
- R5: With pattern flip set, pattern window w gives what window w XOR 4 gives with the flip clear.
- R6: With program swap clear, CPU window 0 (0x8000) gives register 6 and window 2 (0xC000) gives the second-to-last bank. With program swap set, the two are exchanged.
- R7: CPU window 1 (0xA000) always gives register 7, and window 3 (0xE000) always gives the last bank.
- R8: A write to an address with bits 15:13 = 101 and bit 0 = 0 sets mirror_sel to data bit 0.
- R9: Writes with wr_en low, writes outside 0x8000–0xBFFF, and odd-address writes in 0xA000–0xBFFF change no output.
- R10: Each program bank output is its source value modulo PRG_BANKS. Each pattern bank output is its source value modulo CHR_BANKS.
- R11: A synchronous reset clears the command register, all eight bank registers and the mirroring bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_win | input | 2 | CPU address bits 14:13 (program window index) |
| prg_bank | output | $clog2(PRG_BANKS) | Physical 8 KB program bank for cpu_win |
| ppu_win | input | 3 | PPU address bits 12:10 (pattern window index) |
| chr_bank | output | $clog2(CHR_BANKS) | Physical 1 KB pattern bank for ppu_win |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
A write updates the state at the clock edge on which it is sampled. Each bank lookup is combinational from that state and from the window index. So the bench drives a write on a falling edge and releases it on the next falling edge. It then sweeps all four program windows and all eight pattern windows with short settling delays, still before the next rising edge. mirror_sel is a register output and is compared at the same point. Random writes are checked against a bench model that is updated only after each write's clock edge. Directed cases cover both mode bits, ignored writes, oversized bank values and reset.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int NUM_BANK_REGS = 8;
    localparam int REG_W         = 8;

    typedef struct packed {
        logic       chr_flip;
        logic       prg_swap;
        logic [2:0] sel;
    } cmd_t;

    typedef enum logic [1:0] {
        WR_CMD,
        WR_DATA,
        WR_MIRROR,
        WR_NONE
    } wr_kind_e;

    function automatic wr_kind_e decode_write(input logic en, input logic [15:0] addr);
        if (!en)
            return WR_NONE;
        if (addr[15:13] == 3'b100)
            return addr[0] ? WR_DATA : WR_CMD;
        if (addr[15:13] == 3'b101 && !addr[0])
            return WR_MIRROR;
        return WR_NONE;
    endfunction

    function automatic cmd_t cmd_from_byte(input logic [7:0] d);
        cmd_t c;
        c.chr_flip = d[7];
        c.prg_swap = d[6];
        c.sel      = d[2:0];
        return c;
    endfunction

    function automatic logic [2:0] chr_slot(input logic [2:0] win, input logic flip);
        return win ^ {flip, 2'b00};
    endfunction

endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
    import cart_bank_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [15:0]                           wr_addr,
    input  logic [7:0]                            wr_data,
    output cmd_t                                  cmd_q,
    output logic [NUM_BANK_REGS-1:0][REG_W-1:0]   bank_q,
    output logic                                  mirror_q
);
    wr_kind_e kind;

    always_comb kind = decode_write(wr_en, wr_addr);

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (kind == WR_CMD)
            cmd_q <= cmd_from_byte(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mirror_q <= 1'b0;
        else if (kind == WR_MIRROR)
            mirror_q <= wr_data[0];
    end

    for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= '0;
            else if (kind == WR_DATA && cmd_q.sel == 3'(i))
                bank_q[i] <= wr_data;
        end
    end

    assert_cmd_load_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0])
        |=> (cmd_q == {$past(wr_data[7:6]), $past(wr_data[2:0])}));

    assert_data_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:13] == 3'b100 && wr_addr[0])
        |=> (bank_q[$past(cmd_q.sel)] == $past(wr_data)));

    assert_mirror_set_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0])
        |=> (mirror_q == $past(wr_data[0])));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ($stable(cmd_q) && $stable(bank_q) && $stable(mirror_q)));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (cmd_q == '0 && mirror_q == 1'b0 && bank_q == '0));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import cart_bank_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int PRG_W    = $clog2(PRG_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prg_swap,
    input  logic [REG_W-1:0] reg6,
    input  logic [REG_W-1:0] reg7,
    input  logic [1:0]       win,
    output logic [PRG_W-1:0] bank
);
    localparam logic [PRG_W-1:0] LAST_BANK   = PRG_W'(PRG_BANKS - 1);
    localparam logic [PRG_W-1:0] SECOND_LAST = PRG_W'(PRG_BANKS - 2);

    logic [PRG_W-1:0] r6_m, r7_m;

    always_comb begin
        r6_m = reg6[PRG_W-1:0];
        r7_m = reg7[PRG_W-1:0];
        unique case (win)
            2'd0:    bank = prg_swap ? SECOND_LAST : r6_m;
            2'd1:    bank = r7_m;
            2'd2:    bank = prg_swap ? r6_m : SECOND_LAST;
            default: bank = LAST_BANK;
        endcase
    end

    assert_fixed_top_R7: assert property (@(posedge clk) disable iff (rst)
        (win == 2'd3) |-> (bank == LAST_BANK));

    assert_swap_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (win[0] == 1'b0 && (win[1] ^ prg_swap)) |-> (bank == SECOND_LAST));

endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
    import cart_bank_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    localparam int CHR_W    = $clog2(CHR_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   chr_flip,
    input  logic [5:0][REG_W-1:0]  regs,
    input  logic [2:0]             win,
    output logic [CHR_W-1:0]       bank
);
    logic [7:0][CHR_W-1:0] slot_bank;

    for (genvar i = 0; i < 8; i++) begin : g_slot
        if (i < 4) begin : g_pair
            always_comb begin
                slot_bank[i]    = regs[i / 2][CHR_W-1:0];
                slot_bank[i][0] = 1'(i % 2);
            end
        end else begin : g_single
            always_comb slot_bank[i] = regs[i - 2][CHR_W-1:0];
        end
    end

    always_comb bank = slot_bank[chr_slot(win, chr_flip)];

    assert_pair_even_R3: assert property (@(posedge clk) disable iff (rst)
        (!chr_flip && win[2] == 1'b0) |-> (bank[0] == win[0]));

    assert_flip_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (chr_flip && win[2] == 1'b1) |-> (bank[0] == win[0]));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_bank_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 256,
    localparam int PRG_W    = $clog2(PRG_BANKS),
    localparam int CHR_W    = $clog2(CHR_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       cpu_win,
    output logic [PRG_W-1:0] prg_bank,
    input  logic [2:0]       ppu_win,
    output logic [CHR_W-1:0] chr_bank,
    output logic             mirror_sel
);
    cmd_t                                cmd_q;
    logic [NUM_BANK_REGS-1:0][REG_W-1:0] bank_q;
    logic [5:0][REG_W-1:0]               chr_regs;

    bank_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd_q    (cmd_q),
        .bank_q   (bank_q),
        .mirror_q (mirror_sel)
    );

    always_comb chr_regs = bank_q[5:0];

    prg_window_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk      (clk),
        .rst      (rst),
        .prg_swap (cmd_q.prg_swap),
        .reg6     (bank_q[6]),
        .reg7     (bank_q[7]),
        .win      (cpu_win),
        .bank     (prg_bank)
    );

    chr_window_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .clk      (clk),
        .rst      (rst),
        .chr_flip (cmd_q.chr_flip),
        .regs     (chr_regs),
        .win      (ppu_win),
        .bank     (chr_bank)
    );

endmodule

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;
    localparam int PRG_BANKS = 32;
    localparam int CHR_BANKS = 256;
    localparam int PRG_W = $clog2(PRG_BANKS);
    localparam int CHR_W = $clog2(CHR_BANKS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] cpu_win = '0;
    logic [2:0] ppu_win = '0;
    logic [PRG_W-1:0] prg_bank;
    logic [CHR_W-1:0] chr_bank;
    logic mirror_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic       m_flip, m_swap, m_mir;
    logic [2:0] m_sel;
    logic [7:0] m_reg [8];

    always #2.5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_win(cpu_win), .prg_bank(prg_bank), .ppu_win(ppu_win),
        .chr_bank(chr_bank), .mirror_sel(mirror_sel)
    );

    function automatic int exp_prg(input int w);
        case (w)
            0: return m_swap ? PRG_BANKS - 2 : m_reg[6] % PRG_BANKS;
            1: return m_reg[7] % PRG_BANKS;
            2: return m_swap ? m_reg[6] % PRG_BANKS : PRG_BANKS - 2;
            default: return PRG_BANKS - 1;
        endcase
    endfunction

    function automatic int exp_chr(input int w);
        int s;
        int v;
        s = m_flip ? (w ^ 4) : w;
        if (s < 4) v = (m_reg[s / 2] & 8'hFE) | (s % 2);
        else v = m_reg[s - 2];
        return v % CHR_BANKS;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_flip = 0; m_swap = 0; m_mir = 0; m_sel = 0;
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15:13] == 3'b100 && !a[0]) begin
            m_flip = d[7]; m_swap = d[6]; m_sel = d[2:0];
        end else if (a[15:13] == 3'b100) begin
            m_reg[m_sel] = d;
        end else if (a[15:13] == 3'b101 && !a[0]) begin
            m_mir = d[0];
        end
    endtask

    // drive on a falling edge, register on the rising edge, release on the next falling edge
    task automatic do_write(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) model_write(a, d);
    endtask

    // sweep all windows between edges
    task automatic check_all(input string ctx);
        string r;
        for (int w = 0; w < 4; w++) begin
            cpu_win = 2'(w);
            #0.1;
            r = (w == 1 || w == 3) ? "R7" : "R6";
            check(r, $sformatf("%s prg win%0d", ctx, w), int'(prg_bank), exp_prg(w));
        end
        for (int w = 0; w < 8; w++) begin
            ppu_win = 3'(w);
            #0.1;
            r = m_flip ? "R5" : (w < 4 ? "R3" : "R4");
            check(r, $sformatf("%s chr win%0d", ctx, w), int'(chr_bank), exp_chr(w));
        end
        check("R8", {ctx, " mirror"}, int'(mirror_sel), int'(m_mir));
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R11 after reset");

        // R1/R2: each register in all four mode-bit combinations
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 8; r++) begin
                do_write(1, 16'h8000, 8'((m << 6) | r));
                do_write(1, 16'h8001, 8'((r * 37 + m * 11 + 3) & 8'hFF));
                check_all($sformatf("R1 R2 mode%0d reg%0d", m, r));
            end
        end

        // R8: mirroring via both polarities
        do_write(1, 16'hA000, 8'h01); check_all("R8 set");
        do_write(1, 16'hBFFE, 8'hFE); check_all("R8 clear");

        // R9: ignored writes
        do_write(1, 16'hA001, 8'h01);
        check("R9", "odd mirror write", int'(mirror_sel), 0);
        do_write(0, 16'h8000, 8'hC7); check_all("R9 strobe low");
        do_write(1, 16'h6000, 8'hC7); check_all("R9 below window");
        do_write(1, 16'hC001, 8'h55); check_all("R9 above window");

        // R10: oversized bank values wrap by bank count
        do_write(1, 16'h8000, 8'h06);
        do_write(1, 16'h8001, 8'hFF);
        cpu_win = 2'd0; #0.1;
        check("R10", "reg6 0xFF masked", int'(prg_bank), 8'hFF % PRG_BANKS);
        do_write(1, 16'h8000, 8'h07);
        do_write(1, 16'h8001, 8'h41);
        cpu_win = 2'd1; #0.1;
        check("R10", "reg7 0x41 masked", int'(prg_bank), 8'h41 % PRG_BANKS);
        check_all("R10");

        // random traffic across the write windows
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            logic [7:0] d;
            int unsigned pick;
            pick = $urandom % 8;
            d = 8'($urandom);
            case (pick)
                0, 1: a = 16'h8000 | (16'($urandom) & 16'h1FFE);
                2, 3, 4: a = 16'h8001 | (16'($urandom) & 16'h1FFE);
                5: a = 16'hA000 | (16'($urandom) & 16'h1FFE);
                6: a = 16'hA001 | (16'($urandom) & 16'h1FFE);
                default: a = 16'($urandom) & 16'h7FFF;
            endcase
            do_write(($urandom % 16) != 0, a, d);
            if (k % 4 == 3) check_all("random R1 R2 R9");
        end

        // R11: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        check_all("R11 re-reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule